// File: doc/BRIEF.md
# Reverb Work-Area Address Generator

This block supplies every sound-RAM halfword address that a reverb engine reads or writes. The reverb work area is a ring. It starts at a programmable halfword address and ends at the fixed top of sound RAM (halfword 0x40000). A work pointer walks through this ring once per 22.05 kHz sample tick. The engine names a tap, and the block returns that tap's wrapped address relative to the work pointer.

Each tap has an offset register. Software writes it in units of four halfwords. Whenever any register is written, the block converts the raw values to reduced halfword offsets again. It does this with a fixed-length shift-and-subtract modulo sequencer, and it keeps `ready_o` low until the new set is complete. The four feedback taps are not stored as registers of their own. Each is the wrapped difference between a mix-destination offset and one of two feedback registers.

The pointer and the start register are independent of the reverb enable state. The pointer moves on every tick even when the engine is idle.

Top module: `rvb_addr_gen`

## Requirements
- R1: After reset, `ptr_o` is 0, `ready_o` is 1, and every tap address equals `ptr_o`, because all offsets are 0.
- R2: Writing the start register (`wr_addr_i` = 22) with 0xFFFF, or with any value at or below 0x0200, sets both the start address and `ptr_o` to 0 on the following cycle.
- R3: Writing the start register with any other value V loads V×4 into both the start address and `ptr_o` when V×4 differs from the current start. When it equals the current start, `ptr_o` is left unchanged.
- R4: Each cycle with `tick_i` high advances `ptr_o` by one on the next cycle. This holds regardless of any other input, except a start-register load in the same cycle.
- R5: A tick taken while `ptr_o` is 0x3FFFF returns `ptr_o` to the start address.
- R6: `tap_sel_i` values 0 to 19 select plain taps. Tap n uses register n (`wr_addr_i` = n), and its offset is (value×4) mod S, where S = 0x40000 − start. The address is `ptr_o` + offset + `tap_inc_i`, reduced by S when that sum reaches 0x40000.
- R7: `tap_sel_i` values 20 to 23 select feedback taps. Tap 20+k has offset (M − F) wrapped into [0, S). M is the reduced offset of register 16+k. F is the reduced value of register 20 (k = 0 or 1) or register 21 (k = 2 or 3), each scaled ×4 and reduced mod S.
- R8: With `tap_inc_i` high, the address is one sample further on. That extra sample is also wrapped back into the work area.
- R9: Any write to an address from 0 to 22 drives `ready_o` low on the next cycle. `ready_o` returns high within 400 cycles, after which the addresses reflect the new values.
- R10: Writes to addresses 23 to 31 are ignored. `ready_o` stays high and no address changes. A `tap_sel_i` of 24 or more gives offset 0, so the address equals `ptr_o` plus `tap_inc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register index: 0-19 tap offsets, 20/21 feedback, 22 start |
| wr_data_i | input | 16 | Register write value |
| tick_i | input | 1 | Sample tick, one cycle per 22.05 kHz period |
| tap_sel_i | input | 5 | Tap whose address is requested |
| tap_inc_i | input | 1 | Add one sample to the tap address |
| addr_o | output | 18 | Wrapped halfword address of the selected tap |
| ptr_o | output | 18 | Current work pointer |
| ready_o | output | 1 | Offsets are valid for the current register set |

## Verification
Two cases are hard to reach from the ports. The first is the wrap at the top of RAM, which needs the pointer and an offset near 0x40000 at the same time. The bench reaches it by programming a start close to the top, 0x3C000 or 0x3FFC0, so that a few dozen ticks bring the pointer to the edge. The second is a feedback difference that goes negative. The bench reaches it by writing a feedback register larger than its mix-destination partner, and checks the resulting sum against a model of the wrap that uses the modulo operator.

// File: rtl/rvb_addr_pkg.sv
package rvb_addr_pkg;
  localparam int unsigned AW        = 18;
  localparam int unsigned SEL_W     = 5;
  localparam int unsigned N_PLAIN   = 20;
  localparam int unsigned N_FB_REG  = 2;
  localparam int unsigned N_FB      = 4;
  localparam int unsigned N_RAW     = N_PLAIN + N_FB_REG;
  localparam int unsigned N_TAP     = N_PLAIN + N_FB;
  localparam int unsigned REG_START = N_RAW;
  localparam logic [AW:0] RAM_TOP   = 19'h40000;
  localparam logic [15:0] START_MIN = 16'h0200;

  typedef logic [AW-1:0] hw_addr_t;
  typedef logic [AW:0]   hw_wide_t;
endpackage

// File: rtl/rvb_ptr.sv
module rvb_ptr
  import rvb_addr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_we_i,
  input  logic [15:0] start_val_i,
  input  logic        tick_i,
  output hw_addr_t    start_o,
  output hw_addr_t    ptr_o
);
  hw_addr_t start_q, ptr_q, new_start;
  hw_wide_t ptr_inc;
  logic     force_zero, do_load;

  assign force_zero = (start_val_i == 16'hFFFF) || (start_val_i <= START_MIN);
  assign new_start  = force_zero ? '0 : hw_addr_t'({start_val_i, 2'b00});
  // forced zero always reloads; otherwise only a changed start reloads
  assign do_load    = start_we_i && (force_zero || (new_start != start_q));
  assign ptr_inc    = {1'b0, ptr_q} + hw_wide_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      ptr_q   <= '0;
    end else if (do_load) begin
      start_q <= new_start;
      ptr_q   <= new_start;
    end else if (tick_i) begin
      ptr_q <= (ptr_inc >= RAM_TOP) ? start_q : ptr_inc[AW-1:0];
    end
  end

  assign start_o = start_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/rvb_ofs_calc.sv
module rvb_ofs_calc
  import rvb_addr_pkg::*;
#(
  parameter int unsigned MOD_STEPS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [15:0]      wdata_i,
  input  hw_wide_t         space_i,
  output logic             ready_o,
  output hw_addr_t         ofs_o [N_RAW]
);
  localparam int unsigned STEP_W = $clog2(MOD_STEPS);
  localparam int unsigned IDX_W  = $clog2(N_RAW);
  localparam int unsigned CW     = AW + 1 + MOD_STEPS;

  typedef enum logic {ST_IDLE, ST_CALC} st_e;

  logic [15:0]      raw_q [N_RAW];
  hw_addr_t         ofs_q [N_RAW];
  hw_wide_t         val_q;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             dirty_q, wr_hit, last_idx;
  st_e              st_q;
  logic [CW-1:0]    div, val_ext, red;

  function automatic hw_wide_t scale4(input logic [15:0] r);
    return hw_wide_t'({r, 2'b00});
  endfunction

  assign wr_hit   = we_i && (waddr_i <= SEL_W'(REG_START));
  assign last_idx = (idx_q == IDX_W'(N_RAW - 1));
  assign idx_nxt  = last_idx ? '0 : idx_q + 1'b1;
  // restoring reduction: one multiple of space per cycle, largest first
  assign div      = CW'(space_i) << step_q;
  assign val_ext  = CW'(val_q);
  assign red      = (val_ext >= div) ? (val_ext - div) : val_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_RAW; i++) raw_q[i] <= '0;
    end else if (we_i && (waddr_i < SEL_W'(N_RAW))) begin
      raw_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dirty_q <= 1'b0;
      idx_q   <= '0;
      val_q   <= '0;
      step_q  <= '0;
      for (int i = 0; i < N_RAW; i++) ofs_q[i] <= '0;
    end else begin
      dirty_q <= dirty_q | wr_hit;
      case (st_q)
        ST_IDLE: begin
          if (dirty_q) begin
            st_q    <= ST_CALC;
            dirty_q <= wr_hit;
            idx_q   <= '0;
            val_q   <= scale4(raw_q[0]);
            step_q  <= STEP_W'(MOD_STEPS - 1);
          end
        end
        ST_CALC: begin
          if (step_q == '0) begin
            ofs_q[idx_q] <= red[AW-1:0];
            if (last_idx) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_nxt;
              val_q  <= scale4(raw_q[idx_nxt]);
              step_q <= STEP_W'(MOD_STEPS - 1);
            end
          end else begin
            val_q  <= red[AW:0];
            step_q <= step_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ofs_o   = ofs_q;
  assign ready_o = (st_q == ST_IDLE) && !dirty_q;
endmodule

// File: rtl/rvb_tap_addr.sv
module rvb_tap_addr
  import rvb_addr_pkg::*;
(
  input  hw_addr_t         ofs_i [N_RAW],
  input  hw_addr_t         ptr_i,
  input  hw_wide_t         space_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inc_i,
  output hw_addr_t         addr_o
);
  hw_addr_t tap_ofs [N_TAP];
  hw_addr_t sel_ofs;
  hw_wide_t sum;

  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    if (t < N_PLAIN) begin : g_plain
      assign tap_ofs[t] = ofs_i[t];
    end else begin : g_fb
      localparam int unsigned K   = t - N_PLAIN;
      localparam int unsigned MIX = N_PLAIN - N_FB + K;
      localparam int unsigned FBR = N_PLAIN + K / 2;
      assign tap_ofs[t] = (ofs_i[MIX] >= ofs_i[FBR])
                          ? ofs_i[MIX] - ofs_i[FBR]
                          : hw_addr_t'(space_i + {1'b0, ofs_i[MIX]} - {1'b0, ofs_i[FBR]});
    end
  end

  assign sel_ofs = (sel_i < SEL_W'(N_TAP)) ? tap_ofs[sel_i] : '0;
  assign sum     = {1'b0, ptr_i} + {1'b0, sel_ofs} + hw_wide_t'(inc_i);
  assign addr_o  = (sum >= RAM_TOP) ? hw_addr_t'(sum - space_i) : sum[AW-1:0];
endmodule

// File: rtl/rvb_addr_gen.sv
module rvb_addr_gen
  import rvb_addr_pkg::*;
#(
  parameter int unsigned MOD_STEPS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [4:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic        tick_i,
  input  logic [4:0]  tap_sel_i,
  input  logic        tap_inc_i,
  output logic [17:0] addr_o,
  output logic [17:0] ptr_o,
  output logic        ready_o
);
  hw_addr_t start_addr, ptr;
  hw_wide_t space;
  hw_addr_t ofs [N_RAW];
  logic     start_we;

  assign start_we = wr_en_i && (wr_addr_i == SEL_W'(REG_START));
  assign space    = RAM_TOP - {1'b0, start_addr};

  rvb_ptr u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_we_i (start_we),
    .start_val_i(wr_data_i),
    .tick_i     (tick_i),
    .start_o    (start_addr),
    .ptr_o      (ptr)
  );

  rvb_ofs_calc #(.MOD_STEPS(MOD_STEPS)) u_calc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .space_i(space),
    .ready_o(ready_o),
    .ofs_o  (ofs)
  );

  rvb_tap_addr u_tap (
    .ofs_i  (ofs),
    .ptr_i  (ptr),
    .space_i(space),
    .sel_i  (tap_sel_i),
    .inc_i  (tap_inc_i),
    .addr_o (addr_o)
  );

  assign ptr_o = ptr;
endmodule

// File: rtl/rvb_addr_chk.sv
module rvb_addr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [4:0]  wr_addr_i,
  input logic        tick_i,
  input logic [17:0] addr_o,
  input logic [17:0] ptr_o,
  input logic        ready_o,
  input logic [17:0] start_addr
);
  logic start_wr;
  assign start_wr = wr_en_i && (wr_addr_i == 5'd22);

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start_wr && ptr_o != 18'h3FFFF) |=> (ptr_o == $past(ptr_o) + 18'd1)); // R4

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start_wr && ptr_o == 18'h3FFFF) |=> (ptr_o == start_addr)); // R5

  AST_PTR_IN_AREA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o >= start_addr); // R3

  AST_ADDR_IN_AREA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (addr_o >= start_addr)); // R6

  AST_WRITE_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i <= 5'd22) |=> !ready_o); // R9

  AST_UNUSED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > 5'd22 && ready_o) |=> ready_o); // R10
endmodule

bind rvb_addr_gen rvb_addr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .tick_i    (tick_i),
  .addr_o    (addr_o),
  .ptr_o     (ptr_o),
  .ready_o   (ready_o),
  .start_addr(start_addr)
);

// File: tb/tb_rvb_addr_gen.sv
`timescale 1ns/1ps
module tb_rvb_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [4:0]  tap_sel = '0;
  logic        tap_inc = 1'b0;
  logic [17:0] addr, ptr;
  logic        ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_start = 0;
  int m_ptr = 0;
  int m_raw [22];

  always #4 clk = ~clk;

  rvb_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .tap_sel_i(tap_sel), .tap_inc_i(tap_inc),
    .addr_o(addr), .ptr_o(ptr), .ready_o(ready)
  );

  function automatic int m_space();
    return 32'h40000 - m_start;
  endfunction

  function automatic int m_ofs(input int sel);
    int sp, a, b, d, k;
    sp = m_space();
    if (sel < 20) return (m_raw[sel] * 4) % sp;
    if (sel < 24) begin
      k = sel - 20;
      a = (m_raw[16 + k] * 4) % sp;
      b = (m_raw[20 + k / 2] * 4) % sp;
      d = a - b;
      if (d < 0) d += sp;
      return d;
    end
    return 0;
  endfunction

  function automatic int m_addr(input int sel, input int inc);
    int s;
    s = m_ptr + m_ofs(sel) + inc;
    if (s >= 32'h40000) s -= m_space();
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 22) m_raw[a] = d;
    else if (a == 22) begin
      if (d == 16'hFFFF || d <= 16'h0200) begin m_start = 0; m_ptr = 0; end
      else if ((d * 4) != m_start) begin m_start = d * 4; m_ptr = d * 4; end
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      m_ptr = (m_ptr + 1 >= 32'h40000) ? m_start : m_ptr + 1;
    end
  endtask

  task automatic check_tap(input string req, input int sel, input int inc);
    tap_sel = 5'(sel); tap_inc = inc[0];
    #1;
    check(req, int'(addr), m_addr(sel, inc));
    tap_inc = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", int'(ready), 1);
    check("R1 ptr", int'(ptr), 0);
    for (int s = 0; s < 24; s += 7) check_tap("R1 tap", s, 0);
  endtask

  task automatic t_start();
    int n;
    do_write(22, 16'h1000);
    check("R3 load", int'(ptr), 32'h4000);
    wait_ready(n);
    do_tick(3);
    do_write(22, 16'h1000);
    check("R3 same start keeps ptr", int'(ptr), 32'h4003);
    wait_ready(n);
    do_write(22, 16'h0150);
    check("R2 low start", int'(ptr), 0);
    do_write(22, 16'h1000);
    do_write(22, 16'hFFFF);
    check("R2 all ones", int'(ptr), 0);
    do_write(22, 16'h0200);
    check("R2 boundary 0x200", int'(ptr), 0);
    do_write(22, 16'h0201);
    check("R3 just above 0x200", int'(ptr), 32'h804);
    wait_ready(n);
  endtask

  task automatic t_tick();
    int p0;
    p0 = int'(ptr);
    do_tick(5);
    check("R4 five ticks", int'(ptr), p0 + 5);
    check("R4 model", int'(ptr), m_ptr);
  endtask

  task automatic t_wrap();
    int n;
    do_write(22, 16'hFFF0);
    wait_ready(n);
    do_tick(63);
    check("R5 at top", int'(ptr), 32'h3FFFF);
    do_tick(1);
    check("R5 wrapped", int'(ptr), 32'h3FFC0);
  endtask

  task automatic t_plain();
    int n;
    do_write(22, 16'hF000);
    do_write(3, 16'h0FFF);
    do_write(5, 16'h1234);
    wait_ready(n);
    check_tap("R6 tap3 below top", 3, 0);
    check("R6 tap3 abs", int'(addr), 32'h3FFFC);
    check_tap("R6 tap5 reduced", 5, 0);
    do_tick(3);
    check_tap("R8 inc no wrap", 3, 0);
    check_tap("R8 inc wraps", 3, 1);
    check("R8 inc abs", int'(addr), 32'h3C000);
    do_tick(1);
    check_tap("R6 tap3 wraps", 3, 0);
  endtask

  task automatic t_fb();
    int n;
    do_write(22, 16'h8000);
    do_write(16, 16'h0100);
    do_write(17, 16'h0900);
    do_write(18, 16'h0000);
    do_write(19, 16'h7FFF);
    do_write(20, 16'h0200);
    do_write(21, 16'h0010);
    wait_ready(n);
    for (int s = 20; s < 24; s++) check_tap("R7 feedback", s, 0);
    check_tap("R7 negative diff", 20, 0);
    check("R7 abs", int'(addr), 32'h3FC00);
    check_tap("R8 feedback inc", 22, 1);
  endtask

  task automatic t_ready();
    int n;
    do_write(7, 16'h0042);
    check("R9 ready low", int'(ready), 0);
    wait_ready(n);
    check("R9 ready back", int'(ready), 1);
    check("R9 latency bound", int'(n < 400), 1);
    check_tap("R9 new value", 7, 0);
  endtask

  task automatic t_ignored();
    int a7;
    tap_sel = 5'd7; #1; a7 = int'(addr);
    do_write(25, 16'h1111);
    check("R10 ready kept", int'(ready), 1);
    tap_sel = 5'd7; #1;
    check("R10 tap unchanged", int'(addr), a7);
    check_tap("R10 sel out of range", 30, 0);
    check("R10 sel out ptr", int'(addr), int'(ptr));
  endtask

  initial begin
    for (int i = 0; i < 22; i++) m_raw[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_tick();
    t_wrap();
    t_plain();
    t_fb();
    t_ready();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule